// File: doc/BRIEF.md
# Memory Refresh Interval Timer

This block sets the pace for periodic memory refresh. An 8-bit up-counter moves forward on each cycle where a tick-enable input is high. When a tick arrives while the counter equals an 8-bit constant, the block records a compare match. A compare match returns the counter to zero and raises a status flag. If refresh is enabled, it also posts a refresh request to the memory controller. If the interrupt is enabled, the status flag drives an interrupt line.

The refresh request and the interrupt are independent of each other. Only one refresh request is held at a time. A refresh acknowledge from the memory controller retires it. Clearing the status flag never cancels that request. Software can therefore count refreshes by interrupt while refresh runs on its own. While the bus is released to another master, a pending request also drives a refresh-out pin.

Software reaches the block through a small 32-bit register port with three words:

- **Word 0 (control/status):** bit 0 is the match flag, bit 1 is the interrupt enable, bit 2 is the refresh enable.
- **Word 1:** the counter.
- **Word 2:** the constant.

Writes to the counter and to the constant are ignored unless bits 31:16 of the write data hold the key 0xA55A.

Top module: `refresh_interval_timer`

## Requirements
- R1: On a cycle with tick_en high, no compare match and no counter write, the counter increases by one. On a cycle without tick_en and without a counter write, it holds its value.
- R2: A compare match occurs when tick_en is high, the counter equals the constant and no counter write is in progress. On a match, the counter goes to 0 and the flag (word 0 bit 0) is set. A constant of N therefore gives one match every N+1 ticks, and a constant of 0 gives a match on every tick.
- R3: A write to word 2 stores wdata[7:0] only if wdata[31:16] equals 0xA55A. Any other write to word 2 leaves the constant unchanged. Reads of word 2 return the constant in bits 7:0, with bits 31:8 reading as zero.
- R4: A write to word 1 follows the same key rule as word 2. A keyed counter write takes priority over a tick in the same cycle, and that cycle produces no match.
- R5: A match while the refresh enable (word 0 bit 2) is 1 sets refresh_req. refresh_req stays high until a cycle with refresh_ack high. Further matches while it is pending do not add a second request.
- R6: If refresh_ack and a match with refresh enabled fall in the same cycle, refresh_req stays high.
- R7: irq is high when both the flag and the interrupt enable (word 0 bit 1) are 1. Once high, it stays high until software clears the flag or disables the interrupt.
- R8: A write to word 0 with bit 0 at 0 clears the flag only if a read of word 0 has returned the flag as 1 since it was last set. Writing 1 to bit 0 has no effect. A match in the same cycle as a clear keeps the flag set.
- R9: Clearing the flag leaves refresh_req unchanged.
- R10: refresh_out is high exactly when a refresh request is pending and bus_released is high.
- R11: After reset, the counter, the constant, the flag and both enables are 0, and irq, refresh_req and refresh_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word select: 0 control/status, 1 counter, 2 constant |
| reg_wdata | input | 32 | Write data, key in bits 31:16 |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| bus_released | input | 1 | Bus currently granted to an external master |
| refresh_ack | input | 1 | Refresh performed, retires the pending request |
| refresh_req | output | 1 | Pending refresh request |
| refresh_out | output | 1 | Refresh request seen while the bus is released |
| irq | output | 1 | Compare-match interrupt request |

## Verification
The following properties are checked on every cycle:

- the counter steps by one on a plain tick;
- the counter returns to zero on a match;
- a match sets the flag;
- an unkeyed constant write changes nothing;
- refresh_req holds until acknowledged and survives an acknowledge that coincides with a match;
- refresh_out never rises without a pending request on a released bus;
- irq holds between control writes.

Some behaviours are shown only by the bench scenarios:

- the N+1 tick period and the match-every-tick case for a constant of 0;
- the clear of the flag that requires a prior read;
- the independence of flag clearing from the pending refresh;
- mixed random register traffic checked against a reference model.

// File: rtl/rit_pkg.sv
package rit_pkg;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned KEY_W  = 16;
    localparam logic [KEY_W-1:0] WR_KEY = 16'hA55A;

    localparam logic [1:0] WORD_CSR = 2'd0;
    localparam logic [1:0] WORD_CNT = 2'd1;
    localparam logic [1:0] WORD_CMP = 2'd2;

    localparam int unsigned CSR_FLAG = 0;
    localparam int unsigned CSR_IE   = 1;
    localparam int unsigned CSR_RF   = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
    } timebase_t;

    typedef struct packed {
        logic flag;
        logic seen;
        logic ie;
        logic rf;
        logic req;
    } events_t;
endpackage

// File: rtl/rit_timebase.sv
module rit_timebase
    import rit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp,
    output logic             match
);
    timebase_t tb_d, tb_q;

    always_comb begin
        tb_d  = tb_q;
        match = tick_en && !cnt_wr && (tb_q.cnt == tb_q.cmp);
        if (cnt_wr) begin
            tb_d.cnt = wr_val;
        end else if (match) begin
            tb_d.cnt = '0;
        end else if (tick_en) begin
            tb_d.cnt = tb_q.cnt + 1'b1;
        end
        if (cmp_wr) begin
            tb_d.cmp = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign cnt = tb_q.cnt;
    assign cmp = tb_q.cmp;
endmodule

// File: rtl/rit_events.sv
module rit_events
    import rit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic csr_wr,
    input  logic csr_rd,
    input  logic wr_flag,
    input  logic wr_ie,
    input  logic wr_rf,
    input  logic refresh_ack,
    output logic flag,
    output logic ie,
    output logic rf,
    output logic req
);
    events_t ev_d, ev_q;
    logic    clear_req;

    always_comb begin
        ev_d      = ev_q;
        clear_req = csr_wr && !wr_flag && ev_q.seen && ev_q.flag;

        if (match) begin
            ev_d.flag = 1'b1;
        end else if (clear_req) begin
            ev_d.flag = 1'b0;
        end

        if (clear_req || !ev_d.flag) begin
            ev_d.seen = 1'b0;
        end else if (csr_rd && ev_q.flag) begin
            ev_d.seen = 1'b1;
        end

        if (csr_wr) begin
            ev_d.ie = wr_ie;
            ev_d.rf = wr_rf;
        end

        if (match && ev_q.rf) begin
            ev_d.req = 1'b1;
        end else if (refresh_ack) begin
            ev_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign flag = ev_q.flag;
    assign ie   = ev_q.ie;
    assign rf   = ev_q.rf;
    assign req  = ev_q.req;
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
    import rit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bus_released,
    input  logic              refresh_ack,
    output logic              refresh_req,
    output logic              refresh_out,
    output logic              irq
);
    logic             key_ok;
    logic             cnt_wr;
    logic             cmp_wr;
    logic             csr_wr;
    logic             csr_rd;
    logic             match_pulse;
    logic             flag_val;
    logic             ie_en;
    logic             rf_en;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cmp_val;
    logic             unused_wdata;

    assign key_ok       = (reg_wdata[DATA_W-1:DATA_W-KEY_W] == WR_KEY);
    assign cnt_wr       = reg_wr && (reg_addr == WORD_CNT) && key_ok;
    assign cmp_wr       = reg_wr && (reg_addr == WORD_CMP) && key_ok;
    assign csr_wr       = reg_wr && (reg_addr == WORD_CSR);
    assign csr_rd       = reg_rd && (reg_addr == WORD_CSR);
    assign unused_wdata = ^reg_wdata[DATA_W-KEY_W-1:CNT_W];

    rit_timebase i_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_wr  (cnt_wr),
        .cmp_wr  (cmp_wr),
        .wr_val  (reg_wdata[CNT_W-1:0]),
        .cnt     (cnt_val),
        .cmp     (cmp_val),
        .match   (match_pulse)
    );

    rit_events i_events (
        .clk         (clk),
        .rst_n       (rst_n),
        .match       (match_pulse),
        .csr_wr      (csr_wr),
        .csr_rd      (csr_rd),
        .wr_flag     (reg_wdata[CSR_FLAG]),
        .wr_ie       (reg_wdata[CSR_IE]),
        .wr_rf       (reg_wdata[CSR_RF]),
        .refresh_ack (refresh_ack),
        .flag        (flag_val),
        .ie          (ie_en),
        .rf          (rf_en),
        .req         (refresh_req)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            WORD_CSR: begin
                reg_rdata[CSR_FLAG] = flag_val;
                reg_rdata[CSR_IE]   = ie_en;
                reg_rdata[CSR_RF]   = rf_en;
            end
            WORD_CNT: reg_rdata[CNT_W-1:0] = cnt_val;
            WORD_CMP: reg_rdata[CNT_W-1:0] = cmp_val;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq         = flag_val && ie_en;
    assign refresh_out = refresh_req && bus_released;
endmodule

// File: rtl/rit_checker.sv
module rit_checker
    import rit_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              match,
    input logic              cnt_wr,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic              flag,
    input logic              rf_en,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              refresh_ack,
    input logic              refresh_req,
    input logic              refresh_out,
    input logic              bus_released,
    input logic              irq
);
    // R1: plain tick advances the counter by one
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en && !match && !cnt_wr |=> cnt == $past(cnt) + 1'b1);

    // R2: a match returns the counter to zero
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cnt == '0);

    // R2: a match sets the flag
    a_r2_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);

    // R3: an unkeyed constant write leaves the constant alone
    a_r3_key: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == WORD_CMP && reg_wdata[DATA_W-1:DATA_W-KEY_W] != WR_KEY
        |=> $stable(cmp));

    // R5: the request is held until acknowledged
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req && !refresh_ack |=> refresh_req);

    // R6: a match with refresh enabled wins over an acknowledge
    a_r6_collide: assert property (@(posedge clk) disable iff (!rst_n)
        match && rf_en |=> refresh_req);

    // R7: the interrupt holds until the control word is written
    a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(reg_wr && reg_addr == WORD_CSR) |=> irq);

    // R10: refresh_out needs a pending request on a released bus
    a_r10_out: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_out |-> refresh_req && bus_released);
endmodule

bind refresh_interval_timer rit_checker i_rit_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .match        (match_pulse),
    .cnt_wr       (cnt_wr),
    .cnt          (cnt_val),
    .cmp          (cmp_val),
    .flag         (flag_val),
    .rf_en        (rf_en),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .refresh_ack  (refresh_ack),
    .refresh_req  (refresh_req),
    .refresh_out  (refresh_out),
    .bus_released (bus_released),
    .irq          (irq)
);

// File: tb/test_refresh_interval_timer.sv
module test_refresh_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] KEY = 16'hA55A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_released = 1'b0;
    logic        refresh_ack = 1'b0;
    logic        refresh_req;
    logic        refresh_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_cnt = '0, m_cmp = '0;
    logic m_flag = 0, m_seen = 0, m_ie = 0, m_rf = 0, m_req = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_interval_timer i_refresh_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bus_released(bus_released),
        .refresh_ack(refresh_ack), .refresh_req(refresh_req),
        .refresh_out(refresh_out), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return {29'd0, m_rf, m_ie, m_flag};
            2'd1: return {24'd0, m_cnt};
            2'd2: return {24'd0, m_cmp};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_step(input logic t, w, r, input logic [1:0] a,
                              input logic [31:0] d, input logic ack);
        logic key, wrc, wrk, wr0, mt, clr, nflag;
        key = (d[31:16] == KEY);
        wrc = w && a == 2'd1 && key;
        wrk = w && a == 2'd2 && key;
        wr0 = w && a == 2'd0;
        mt  = t && !wrc && (m_cnt == m_cmp);
        clr = wr0 && !d[0] && m_seen && m_flag;
        nflag = mt ? 1'b1 : (clr ? 1'b0 : m_flag);
        if (clr || !nflag) m_seen = 1'b0;
        else if (r && a == 2'd0 && m_flag) m_seen = 1'b1;
        if (mt && m_rf) m_req = 1'b1;
        else if (ack) m_req = 1'b0;
        if (wrc) m_cnt = d[7:0];
        else if (mt) m_cnt = '0;
        else if (t) m_cnt = m_cnt + 1'b1;
        if (wrk) m_cmp = d[7:0];
        if (wr0) begin m_ie = d[1]; m_rf = d[2]; end
        m_flag = nflag;
    endtask

    // one clock: drive at negedge, check read data, update model at edge, check outputs
    task automatic cyc(input logic t, w, r, input logic [1:0] a,
                       input logic [31:0] d, input logic ack, bus);
        @(negedge clk);
        tick_en = t; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
        refresh_ack = ack; bus_released = bus;
        #1;
        if (r) check(a == 2'd0 ? "R8 csr read" : a == 2'd1 ? "R1 cnt read" :
                     a == 2'd2 ? "R3 cmp read" : "R3 spare read",
                     reg_rdata, model_read(a));
        @(posedge clk);
        model_step(t, w, r, a, d, ack);
        #1;
        check("R7 irq", {31'd0, irq}, {31'd0, m_flag && m_ie});
        check("R5 refresh_req", {31'd0, refresh_req}, {31'd0, m_req});
        check("R10 refresh_out", {31'd0, refresh_out}, {31'd0, m_req && bus});
    endtask

    task automatic idle(); cyc(0, 0, 0, 2'd0, 32'd0, 0, 0); endtask
    task automatic wr(input logic [1:0] a, input logic [31:0] d); cyc(0, 1, 0, a, d, 0, 0); endtask
    task automatic rd(input logic [1:0] a); cyc(0, 0, 1, a, 32'd0, 0, 0); endtask
    task automatic tick(); cyc(1, 0, 0, 2'd0, 32'd0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R11: reset state
        check("R11 irq", {31'd0, irq}, 32'd0);
        check("R11 req", {31'd0, refresh_req}, 32'd0);
        rd(2'd0); rd(2'd1); rd(2'd2);

        // R3: bad key then good key
        wr(2'd2, {16'h1234, 16'h0005});
        rd(2'd2);
        check("R3 unkeyed write ignored", model_read(2'd2), 32'd0);
        wr(2'd2, {KEY, 16'hFF03});
        rd(2'd2);
        check("R3 keyed write", {24'd0, i_dummy_cmp()}, 32'd3);

        // R2: period of N+1 ticks
        wr(2'd1, {KEY, 16'h0000});
        wr(2'd0, 32'h6);
        repeat (3) tick();
        check("R2 no match before N+1 ticks", {31'd0, irq}, 32'd0);
        tick();
        check("R2 match at tick N+1", {31'd0, irq}, 32'd1);
        check("R5 request after match", {31'd0, refresh_req}, 32'd1);

        // R8 / R9: clear needs prior read; request survives
        wr(2'd0, 32'h6);
        check("R8 clear without read ignored", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h7);
        check("R8 write 1 no effect", {31'd0, irq}, 32'd1);
        rd(2'd0);
        wr(2'd0, 32'h6);
        check("R8 clear after read", {31'd0, irq}, 32'd0);
        check("R9 request kept after clear", {31'd0, refresh_req}, 32'd1);

        // R2 / R6: constant 0 matches every tick; ack collides with match
        wr(2'd2, {KEY, 16'h0000});
        tick();
        rd(2'd1);
        check("R2 cnt zero with cmp 0", model_read(2'd1), 32'd0);
        cyc(1, 0, 0, 2'd0, 32'd0, 1, 1);
        check("R6 ack with match keeps req", {31'd0, refresh_req}, 32'd1);
        cyc(0, 0, 0, 2'd0, 32'd0, 1, 1);
        check("R5 ack retires req", {31'd0, refresh_req}, 32'd0);

        // R4: keyed counter write beats tick
        wr(2'd2, {KEY, 16'h0040});
        cyc(1, 1, 0, 2'd1, {KEY, 16'h0021}, 0, 0);
        rd(2'd1);
        check("R4 counter write wins", model_read(2'd1), 32'h21);
        cyc(1, 1, 0, 2'd1, {16'h0BAD, 16'h0009}, 0, 0);
        rd(2'd1);
        check("R4 unkeyed counter write ignored", model_read(2'd1), 32'h22);

        // random traffic
        wr(2'd2, {KEY, 16'h0004});
        for (int i = 0; i < 4000; i++) begin
            logic t, w, r, ack, bus;
            logic [1:0] a;
            logic [31:0] d;
            t   = ($urandom % 2) == 0;
            w   = ($urandom % 8) == 0;
            r   = ($urandom % 4) == 0;
            ack = ($urandom % 6) == 0;
            bus = ($urandom % 2) == 0;
            a   = 2'($urandom % 4);
            d   = {(($urandom % 4) != 0) ? KEY : 16'($urandom),
                   8'($urandom), 8'($urandom % 7)};
            if (a == 2'd0 && w) d[2:0] = 3'($urandom);
            cyc(t, w, r, a, d, ack, bus);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic logic [7:0] i_dummy_cmp();
        return reg_rdata[7:0];
    endfunction
endmodule